// File: doc/BRIEF.md
# Three-Phase Center-Aligned Complementary PWM Generator with Dead Band

This block drives the six gate signals of a three-leg bridge. An up/down counter forms a symmetric triangular carrier. For each leg, the block takes a compare value and a two-bit drive mode from the commutation logic and produces one high-side and one low-side gate. A leg can run pulse-width modulation, hold its low switch on, or float with both switches off, so one set of inputs serves both six-step and fully modulated drive.

Each leg's pair of gates is kept apart by a programmable dead band on every edge. Pulses too narrow to survive the dead band are removed. Period, compare values, modes and dead band are captured only at the carrier bottom, so firmware may rewrite them at any moment without causing a glitch.

An external overcurrent comparator bit forces every gate low in the same cycle it rises. The fault stays latched until it is cleared. A one-cycle strobe at the carrier top marks the point where all high sides are off, for current sampling.

Top module: `cpwm_deadband_top`

## Requirements
- R1: The carrier counts 0,1,…,P then P−1,…,1,0 and repeats, one period being 2P clock cycles; P values below 2 are treated as 2. `top_o` is high for exactly one cycle per period, the cycle in which the counter equals P.
- R2: Mode encoding per leg is 2'b00 float, 2'b01 low-hold, 2'b10 PWM, 2'b11 float. In PWM mode with compare value D, the high-side request is on while counter < D: that is 2D−1 cycles per period for 1 ≤ D ≤ P, none for D = 0, and all 2P for D > P. The request is centred on the carrier bottom.
- R3: Every switch-on of a gate follows at least max(T,1) cycles with both gates of that leg low, where T is the dead band in clock cycles. In steady PWM, the high gate is on for (request width − T) cycles per period, the low gate for (2P − request width − T), and the two gates of a leg are never high together.
- R4: Changes to period, compare values, modes and dead band on the inputs take effect only from the carrier bottom that follows the change.
- R5: A floating leg keeps both of its gates low.
- R6: A low-hold leg keeps its low gate on and its high gate off.
- R7: A high-side request narrower than 2T cycles is dropped, so the leg stays on its low gate for the whole period. A low-side interval narrower than 2T keeps the high gate on for the whole period.
- R8: While `trip_i` is high, all six gates are low in that same cycle. `fault_o` is high from the next cycle on.
- R9: `fault_o` stays high until `clr_i` is sampled high in a cycle where `trip_i` is low. A clear that arrives while `trip_i` is high has no effect.
- R10: After a clear, every gate stays low for T cycles before any gate turns on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_i | input | CNT_W | Carrier half period P in cycles |
| duty_i | input | NPH x CNT_W | Per-leg compare value D, leg 0 in the low bits |
| mode_i | input | NPH x 2 | Per-leg drive mode (see R2) |
| dt_i | input | DT_W | Dead band T in cycles |
| trip_i | input | 1 | Overcurrent trip from an external comparator |
| clr_i | input | 1 | Fault clear request |
| gate_hi_o | output | NPH | High-side gate per leg |
| gate_lo_o | output | NPH | Low-side gate per leg |
| fault_o | output | 1 | Latched trip indication |
| top_o | output | 1 | Carrier-top strobe, one cycle |

## Verification
The hardest case to reach is the recovery after a trip. The design must show that the dead band restarts from zero at the clear, rather than carrying on from counting done before the trip. To test this, the bench first holds one leg in low-hold mode. It then trips, tries a clear while the trip is still high, and finally clears. It checks the exact cycle in which the low gate comes back. The shadow-load rule is reached by changing the period in the top strobe cycle. The bench then measures the next top-to-top interval, which is made of the old descending half and the new ascending half.

// File: rtl/cpwm_pkg.sv
// Shared types for the complementary PWM generator.
// Assumes: modes are 2-bit codes as listed in the requirements.
package cpwm_pkg;
    localparam logic [1:0] MODE_FLOAT = 2'b00;
    localparam logic [1:0] MODE_LOW   = 2'b01;
    localparam logic [1:0] MODE_PWM   = 2'b10;

    typedef enum logic [1:0] {
        LEG_OFF = 2'b00,
        LEG_HI  = 2'b01,
        LEG_LO  = 2'b10
    } leg_state_e;
endpackage

// File: rtl/cpwm_timebase.sv
// Up/down carrier and shadow registers.
// The counter runs 0..P..1 and repeats. All configuration is captured
// on the edge that brings the counter to zero, and each leg's compare
// value is converted there to an effective value that already applies
// the narrow-pulse rule.
// Assumes: DT_W <= CNT_W.
module cpwm_timebase #(
    parameter int CNT_W = 16,
    parameter int DT_W  = 10,
    parameter int NPH   = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CNT_W-1:0]            period_i,
    input  logic [NPH-1:0][CNT_W-1:0]   duty_i,
    input  logic [NPH-1:0][1:0]         mode_i,
    input  logic [DT_W-1:0]             dt_i,
    output logic [CNT_W-1:0]            cnt_o,
    output logic                        top_o,
    output logic [NPH-1:0][CNT_W:0]     deff_o,
    output logic [NPH-1:0][1:0]         mode_o,
    output logic [DT_W-1:0]             dt_o
);
    localparam int HW = CNT_W + 2;

    logic [CNT_W-1:0] cnt_q;
    logic             up_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] per_ld;

    // Compare value after the narrow-pulse rule for period p, dead band t.
    function automatic logic [CNT_W:0] eff_duty(input logic [CNT_W-1:0] d,
                                                input logic [CNT_W-1:0] p,
                                                input logic [DT_W-1:0]  t);
        logic [HW-1:0] hw, lw, tw;
        tw = HW'(t) << 1;
        if (d == '0)      hw = '0;
        else if (d > p)   hw = HW'(p) << 1;
        else              hw = (HW'(d) << 1) - HW'(1);
        lw = (HW'(p) << 1) - hw;
        if (hw != '0 && hw < tw)       eff_duty = '0;
        else if (lw != '0 && lw < tw)  eff_duty = {1'b0, p} + 1'b1;
        else if (d > p)                eff_duty = {1'b0, p} + 1'b1;
        else                           eff_duty = {1'b0, d};
    endfunction

    // Clamp the requested period to the minimum usable value.
    always_comb begin
        per_ld = (period_i < CNT_W'(2)) ? CNT_W'(2) : period_i;
    end

    // Carrier stepping and shadow capture at the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= CNT_W'(1);
            up_q   <= 1'b0;
            per_q  <= CNT_W'(2);
            dt_o   <= '0;
            deff_o <= '0;
            mode_o <= '0;
        end else if (up_q) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q + 1'b1 == per_q) up_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
                up_q   <= 1'b1;
                per_q  <= per_ld;
                dt_o   <= dt_i;
                mode_o <= mode_i;
                for (int i = 0; i < NPH; i++)
                    deff_o[i] <= eff_duty(duty_i[i], per_ld, dt_i);
            end
        end
    end

    assign cnt_o = cnt_q;
    assign top_o = (cnt_q == per_q);

    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= per_q);
    assert_top_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        top_o |=> !top_o);
    assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q || cnt_q != CNT_W'(1)) |=> ($stable(per_q) && $stable(dt_o) && $stable(mode_o)));
endmodule

// File: rtl/cpwm_leg.sv
// One bridge leg: request selection and dead-band sequencing.
// The leg state moves through OFF between HI and LO and leaves OFF
// only after dead-band cycles with both gates low. A kill input
// forces OFF and restarts the dead-band count.
// Assumes: mode and compare values change only at the carrier bottom.
module cpwm_leg
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DT_W  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W:0]   deff_i,
    input  logic [1:0]       mode_i,
    input  logic [DT_W-1:0]  dt_i,
    input  logic             kill_i,
    output logic             hi_o,
    output logic             lo_o
);
    leg_state_e      st_q;
    leg_state_e      req;
    logic [DT_W-1:0] off_q;
    logic            off_done;

    // Decode the requested switch state from mode and carrier compare.
    always_comb begin
        case (mode_i)
            MODE_PWM: req = ({1'b0, cnt_i} < deff_i) ? LEG_HI : LEG_LO;
            MODE_LOW: req = LEG_LO;
            default:  req = LEG_OFF;
        endcase
    end

    assign off_done = ({1'b0, off_q} + 1'b1) >= {1'b0, dt_i};

    // Sequence the leg through the dead band and count both-off cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= LEG_OFF;
            off_q <= '0;
        end else if (kill_i) begin
            st_q  <= LEG_OFF;
            off_q <= '0;
        end else if (st_q != LEG_OFF && req != st_q) begin
            st_q  <= LEG_OFF;
            off_q <= '0;
        end else if (st_q == LEG_OFF) begin
            if (req != LEG_OFF && off_done) st_q <= req;
            else if (off_q != '1)           off_q <= off_q + 1'b1;
        end
    end

    assign hi_o = (st_q == LEG_HI) && !kill_i;
    assign lo_o = (st_q == LEG_LO) && !kill_i;

    assert_hi_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_o) |-> $past(!lo_o));
    assert_lo_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_o) |-> $past(!hi_o));
    assert_float_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_PWM && mode_i != MODE_LOW && $past(mode_i) != MODE_PWM
         && $past(mode_i) != MODE_LOW) |-> (!hi_o && !lo_o));
    assert_low_nohi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_LOW && $past(mode_i) == MODE_LOW) |-> !hi_o);
endmodule

// File: rtl/cpwm_trip.sv
// Overcurrent fault latch.
// Sets on the trip input and clears only on a clear request while the
// trip input is low. The kill output combines the live trip with the
// latched state, so gates drop in the same cycle the trip rises.
module cpwm_trip (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    input  logic clr_i,
    output logic fault_o,
    output logic kill_o
);
    logic fault_q;

    // Latch the fault until a clear with the trip released.
    always_ff @(posedge clk) begin
        if (!rst_n)            fault_q <= 1'b0;
        else if (trip_i)       fault_q <= 1'b1;
        else if (clr_i)        fault_q <= 1'b0;
    end

    assign fault_o = fault_q;
    assign kill_o  = fault_q || trip_i;

    assert_fault_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trip_i |=> fault_q);
    assert_fault_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_q && !(clr_i && !trip_i)) |=> fault_q);
endmodule

// File: rtl/cpwm_deadband_top.sv
// Three-leg center-aligned complementary PWM generator with dead band.
// Connects the carrier, one sequencer per leg and the fault latch.
// Assumes: dead band and period are given in clock cycles.
module cpwm_deadband_top #(
    parameter int CNT_W = 16,
    parameter int DT_W  = 10,
    parameter int NPH   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CNT_W-1:0]          period_i,
    input  logic [NPH-1:0][CNT_W-1:0] duty_i,
    input  logic [NPH-1:0][1:0]       mode_i,
    input  logic [DT_W-1:0]           dt_i,
    input  logic                      trip_i,
    input  logic                      clr_i,
    output logic [NPH-1:0]            gate_hi_o,
    output logic [NPH-1:0]            gate_lo_o,
    output logic                      fault_o,
    output logic                      top_o
);
    logic [CNT_W-1:0]          cnt;
    logic [NPH-1:0][CNT_W:0]   deff;
    logic [NPH-1:0][1:0]       mode_act;
    logic [DT_W-1:0]           dt_act;
    logic                      kill;

    cpwm_timebase #(.CNT_W(CNT_W), .DT_W(DT_W), .NPH(NPH)) u_tb (
        .clk(clk), .rst_n(rst_n), .period_i(period_i), .duty_i(duty_i),
        .mode_i(mode_i), .dt_i(dt_i), .cnt_o(cnt), .top_o(top_o),
        .deff_o(deff), .mode_o(mode_act), .dt_o(dt_act)
    );

    cpwm_trip u_trip (
        .clk(clk), .rst_n(rst_n), .trip_i(trip_i), .clr_i(clr_i),
        .fault_o(fault_o), .kill_o(kill)
    );

    for (genvar g = 0; g < NPH; g++) begin : g_leg
        cpwm_leg #(.CNT_W(CNT_W), .DT_W(DT_W)) u_leg (
            .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .deff_i(deff[g]),
            .mode_i(mode_act[g]), .dt_i(dt_act), .kill_i(kill),
            .hi_o(gate_hi_o[g]), .lo_o(gate_lo_o[g])
        );
    end

    assert_trip_gates_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trip_i |-> (gate_hi_o == '0 && gate_lo_o == '0));
    assert_fault_gates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (gate_hi_o == '0 && gate_lo_o == '0));
    assert_no_shoot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi_o & gate_lo_o) == '0);
endmodule

// File: tb/cpwm_deadband_top_tb.sv
module cpwm_deadband_top_tb;
    localparam int CNT_W = 16;
    localparam int DT_W  = 10;
    localparam int NPH   = 3;
    localparam int P     = 20;

    typedef struct packed {
        logic [7:0]      dt;
        logic [2:0][7:0] duty;
        logic [2:0][1:0] mode;
        logic [2:0][7:0] ehi;
        logic [2:0][7:0] elo;
    } vec_t;

    // Entries list legs as {leg2, leg1, leg0}; period fixed at P = 20.
    localparam vec_t VECS [5] = '{
        '{8'd3, '{8'd15, 8'd5, 8'd10}, '{2'd2, 2'd2, 2'd2}, '{8'd26, 8'd6, 8'd16}, '{8'd8, 8'd28, 8'd18}},
        '{8'd4, '{8'd20, 8'd0, 8'd3},  '{2'd2, 2'd2, 2'd2}, '{8'd40, 8'd0, 8'd0},  '{8'd0, 8'd40, 8'd40}},
        '{8'd2, '{8'd8, 8'd0, 8'd0},   '{2'd2, 2'd1, 2'd0}, '{8'd13, 8'd0, 8'd0},  '{8'd23, 8'd40, 8'd0}},
        '{8'd5, '{8'd6, 8'd5, 8'd25},  '{2'd2, 2'd2, 2'd2}, '{8'd6, 8'd0, 8'd40},  '{8'd24, 8'd40, 8'd0}},
        '{8'd3, '{8'd10, 8'd10, 8'd10},'{2'd3, 2'd3, 2'd3}, '{8'd0, 8'd0, 8'd0},   '{8'd0, 8'd0, 8'd0}}
    };

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic [CNT_W-1:0]          period_i = CNT_W'(P);
    logic [NPH-1:0][CNT_W-1:0] duty_i = '0;
    logic [NPH-1:0][1:0]       mode_i = '0;
    logic [DT_W-1:0]           dt_i = DT_W'(2);
    logic                      trip_i = 1'b0;
    logic                      clr_i = 1'b0;
    logic [NPH-1:0]            gate_hi_o, gate_lo_o;
    logic                      fault_o, top_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    cpwm_deadband_top #(.CNT_W(CNT_W), .DT_W(DT_W), .NPH(NPH)) u_dut (
        .clk(clk), .rst_n(rst_n), .period_i(period_i), .duty_i(duty_i),
        .mode_i(mode_i), .dt_i(dt_i), .trip_i(trip_i), .clr_i(clr_i),
        .gate_hi_o(gate_hi_o), .gate_lo_o(gate_lo_o), .fault_o(fault_o),
        .top_o(top_o)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_top();
        @(negedge clk);
        while (!top_o) @(negedge clk);
    endtask

    task automatic load_vec(input vec_t v);
        dt_i = DT_W'(v.dt);
        for (int i = 0; i < NPH; i++) begin
            duty_i[i] = CNT_W'(v.duty[i]);
            mode_i[i] = v.mode[i];
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                bad++;
                total++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        int n;
        int hi_c [NPH];
        int lo_c [NPH];
        int ovl;

        // Reset state
        repeat (4) @(negedge clk);
        check("R1 reset top", int'(top_o), 0);
        check("R5 reset hi", int'(gate_hi_o), 0);
        check("R5 reset lo", int'(gate_lo_o), 0);
        check("R8 reset fault", int'(fault_o), 0);
        rst_n = 1'b1;

        // Vector table: steady per-period gate counts
        for (int v = 0; v < 5; v++) begin
            load_vec(VECS[v]);
            repeat (3) wait_top();
            for (int i = 0; i < NPH; i++) begin hi_c[i] = 0; lo_c[i] = 0; end
            ovl = 0;
            for (int s = 0; s < 2 * P; s++) begin
                for (int i = 0; i < NPH; i++) begin
                    hi_c[i] += int'(gate_hi_o[i]);
                    lo_c[i] += int'(gate_lo_o[i]);
                end
                if ((gate_hi_o & gate_lo_o) != '0) ovl++;
                @(negedge clk);
            end
            for (int i = 0; i < NPH; i++) begin
                check($sformatf("R2 R3 R5 R6 R7 vec%0d leg%0d hi", v, i), hi_c[i], int'(VECS[v].ehi[i]));
                check($sformatf("R2 R3 R5 R6 R7 vec%0d leg%0d lo", v, i), lo_c[i], int'(VECS[v].elo[i]));
            end
            check($sformatf("R3 vec%0d overlap", v), ovl, 0);
        end

        // R1: top-to-top interval is 2P
        wait_top();
        n = 0;
        do begin @(negedge clk); n++; end while (!top_o);
        check("R1 period", n, 2 * P);

        // R4: period change in top cycle applies only from next bottom
        wait_top();
        period_i = CNT_W'(12);
        n = 0;
        do begin @(negedge clk); n++; end while (!top_o);
        check("R4 mixed interval", n, P + 12);
        n = 0;
        do begin @(negedge clk); n++; end while (!top_o);
        check("R4 new interval", n, 24);
        period_i = CNT_W'(P);
        repeat (3) wait_top();

        // Trip sequence with leg1 held low, dead band 2
        load_vec(VECS[2]);
        repeat (3) wait_top();
        repeat (5) @(negedge clk);
        check("R6 lo held before trip", int'(gate_lo_o[1]), 1);
        trip_i = 1'b1;
        #1;
        check("R8 gates off same cycle hi", int'(gate_hi_o), 0);
        check("R8 gates off same cycle lo", int'(gate_lo_o), 0);
        @(negedge clk);
        check("R8 fault set", int'(fault_o), 1);
        trip_i = 1'b0;
        repeat (5) @(negedge clk);
        check("R9 fault latched", int'(fault_o), 1);
        check("R9 gates off while latched", int'(gate_lo_o), 0);
        trip_i = 1'b1;
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        trip_i = 1'b0;
        @(negedge clk);
        check("R9 clear during trip ignored", int'(fault_o), 1);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        check("R9 fault cleared", int'(fault_o), 0);
        check("R10 recover s1 hi", int'(gate_hi_o), 0);
        check("R10 recover s1 lo", int'(gate_lo_o), 0);
        @(negedge clk);
        check("R10 recover s2 lo", int'(gate_lo_o[1]), 0);
        @(negedge clk);
        check("R10 recover s3 lo", int'(gate_lo_o[1]), 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule